// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Array with Pin Feedback

This block is a configurable sum-of-products logic array with a programmable AND plane and a hard-wired OR plane. It has a set of output sections. Each section owns a small fixed group of product terms, and it ORs those terms to form its value. Each section also has one extra product term that decides whether its I/O pin is driven. Every pin value is fed back into the AND plane as an additional input. A section can therefore build a first-pass helper sum that other sections consume. A section whose enable term is false lets its pin act as a plain input.

The AND-plane codes are loaded one product term at a time through a synchronous write port. The logic path from inputs to outputs is combinational. Feedback settles through a fixed number of unrolled evaluation levels, so the netlist contains no combinational loop. A configuration in which a section always drives its pin and also reads that same pin is reported through a sticky per-section flag. The flag is raised shortly after the offending write.

Top module: `pal_core`

## Requirements
- R1: A synchronous active-high reset sets every code field to force-zero and clears all loop flags. While no write follows, `out_val`, `out_en` and `loop_err` are then all zero for any input.
- R2: Each product term holds one 2-bit code per AND-plane signal, at bits [2j+1:2j] of the term word for signal j. Code 2'b01 takes the signal true, 2'b10 takes it complemented, 2'b11 ignores it, and 2'b00 forces the whole term to 0. The term is the AND of all its fields.
- R3: The AND-plane signals are ordered as `ded_in[N_IN-1:0]` at j = 0..N_IN-1, followed by the feedback of pin i at j = N_IN+i.
- R4: Term address s*(N_PT+1)+k, for k < N_PT, is sum term k of section s. `out_val[s]` is the OR of exactly those N_PT terms and of no term belonging to another section.
- R5: Term address s*(N_PT+1)+N_PT is the enable term of section s, and its value appears on `out_en[s]`.
- R6: The feedback of pin i equals `out_val[i]` when `out_en[i]` is 1 and `pin_in[i]` when `out_en[i]` is 0.
- R7: For any configuration whose section dependencies through driven pins are acyclic, outputs settle combinationally. This includes a helper sum in one section consumed by another section, whatever their indices.
- R8: A write with `cfg_we` high stores `cfg_data` at `cfg_addr` on that clock edge, and the outputs reflect it only after that edge. Addresses at or above N_SEC*(N_PT+1) change nothing.
- R9: A term whose fields are all 2'b11 is constant 1. A section whose sum terms are all force-zero outputs constant 0.
- R10: `loop_err[s]` becomes 1 one clock after a write leaves section s with an all-2'b11 enable term while one of its sum terms uses pin s feedback (code 2'b01 or 2'b10). It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Product-term write strobe |
| cfg_addr | input | TERM_AW | Product-term address |
| cfg_data | input | 2*(N_IN+N_SEC) | Code word for the addressed term |
| ded_in | input | N_IN | Dedicated array inputs |
| pin_in | input | N_SEC | Externally applied pin values |
| out_val | output | N_SEC | Value each section would drive |
| out_en | output | N_SEC | Pin drive enable per section |
| loop_err | output | N_SEC | Sticky self-feedback hazard flags |

## Verification
The bench aims at the feedback selector with both enable states. A design that picked the wrong source would show the external pin value where the section's own result belongs, or the reverse. It builds a six-product function from a four-term helper placed in a higher-numbered section than its consumer and checks all input combinations. A design with too few settle levels or an index-ordered evaluation would return stale helper values there. It also probes the write edge, out-of-range addresses and the one-cycle delay and stickiness of the loop flag. A design that got these wrong would show a new code early, corrupt a term, or flag or clear a hazard at the wrong time.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Default geometry of the array
    localparam int PAL_N_IN  = 4;  // dedicated inputs
    localparam int PAL_N_SEC = 4;  // output sections / pins
    localparam int PAL_N_PT  = 4;  // sum terms per section

    // Per-signal code inside a product term (R2)
    typedef enum logic [1:0] {
        SC_ZERO = 2'b00,  // term forced to 0
        SC_TRUE = 2'b01,  // signal taken true
        SC_COMP = 2'b10,  // signal taken complemented
        SC_ANY  = 2'b11   // signal ignored
    } sig_code_e;

    // Contribution of one signal field to its product term
    function automatic logic code_hit(sig_code_e c, logic s);
        logic r;
        case (c)
            SC_TRUE: r = s;
            SC_COMP: r = ~s;
            SC_ANY:  r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // A field that reads its signal (true or complemented)
    function automatic logic code_reads(logic [1:0] c);
        return c[1] ^ c[0];
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
    parameter int N_IN  = pal_pkg::PAL_N_IN,
    parameter int N_SEC = pal_pkg::PAL_N_SEC,
    parameter int N_PT  = pal_pkg::PAL_N_PT,
    parameter int TERM_AW = $clog2(N_SEC * (N_PT + 1))
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            cfg_we,
    input  logic [TERM_AW-1:0]                              cfg_addr,
    input  logic [2*(N_IN+N_SEC)-1:0]                       cfg_data,
    output logic [N_SEC*(N_PT+1)-1:0][2*(N_IN+N_SEC)-1:0]   fuses,
    output logic [N_SEC-1:0]                                loop_err
);
    localparam int N_TPS  = N_PT + 1;
    localparam int N_TERM = N_SEC * N_TPS;
    localparam int TW     = 2 * (N_IN + N_SEC);

    logic [N_TERM-1:0][TW-1:0] fuses_q;
    logic [N_SEC-1:0]          loop_err_q;
    logic                      pend_q;
    logic [N_SEC-1:0]          hazard;
    logic                      addr_ok;

    assign addr_ok = (int'(cfg_addr) < N_TERM);

    // Term store and write-pending marker (R1, R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            fuses_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            pend_q <= cfg_we;
            if (cfg_we && addr_ok) begin
                fuses_q[cfg_addr] <= cfg_data;
            end
        end
    end

    // Self-feedback hazard per section (R10)
    for (genvar s = 0; s < N_SEC; s++) begin : g_haz
        localparam int EN_T  = s * N_TPS + N_PT;
        localparam int FB_LO = 2 * (N_IN + s);
        logic [N_PT-1:0] reads_self;
        for (genvar k = 0; k < N_PT; k++) begin : g_rd
            assign reads_self[k] = pal_pkg::code_reads(fuses_q[s * N_TPS + k][FB_LO +: 2]);
        end
        assign hazard[s] = (&fuses_q[EN_T]) && (|reads_self);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loop_err_q <= '0;
        end else if (pend_q) begin
            loop_err_q <= loop_err_q | hazard;
        end
    end

    assign fuses    = fuses_q;
    assign loop_err = loop_err_q;

    // R10: a raised flag never drops without reset
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (loop_err_q != '0) |=> ((loop_err_q & $past(loop_err_q)) == $past(loop_err_q)));

    // R10: flags only change in the cycle after a write
    a_r10_flag_after_write: assert property (@(posedge clk) disable iff (rst)
        (loop_err_q != $past(loop_err_q)) |-> $past(pend_q));

    // R8: no write, no change to the stored codes
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(fuses_q));

    // R8: an in-range write lands on the next edge
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && addr_ok) |=> (fuses_q[$past(cfg_addr)] == $past(cfg_data)));

endmodule

// File: rtl/pal_plane.sv
module pal_plane #(
    parameter int N_IN  = pal_pkg::PAL_N_IN,
    parameter int N_SEC = pal_pkg::PAL_N_SEC,
    parameter int N_PT  = pal_pkg::PAL_N_PT
) (
    input  logic [N_SEC*(N_PT+1)-1:0][2*(N_IN+N_SEC)-1:0] fuses,
    input  logic [N_IN-1:0]                               ded_in,
    input  logic [N_SEC-1:0]                              fb,
    output logic [N_SEC-1:0]                              val,
    output logic [N_SEC-1:0]                              en
);
    localparam int N_SIG  = N_IN + N_SEC;
    localparam int N_TPS  = N_PT + 1;
    localparam int N_TERM = N_SEC * N_TPS;

    logic [N_SIG-1:0]  sig;
    logic [N_TERM-1:0] hit_vec;

    // Signal order: dedicated inputs low, pin feedback high (R3)
    assign sig = {fb, ded_in};

    // Programmable AND plane (R2)
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int j = 0; j < N_SIG; j++) begin
                hit = hit & pal_pkg::code_hit(pal_pkg::sig_code_e'(fuses[t][2*j +: 2]), sig[j]);
            end
        end
        assign hit_vec[t] = hit;
    end

    // Fixed OR plane and enable term per section (R4, R5)
    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        assign val[s] = |hit_vec[s * N_TPS +: N_PT];
        assign en[s]  = hit_vec[s * N_TPS + N_PT];
    end

endmodule

// File: rtl/pal_core.sv
module pal_core #(
    parameter int N_IN  = pal_pkg::PAL_N_IN,
    parameter int N_SEC = pal_pkg::PAL_N_SEC,
    parameter int N_PT  = pal_pkg::PAL_N_PT,
    parameter int TERM_AW = $clog2(N_SEC * (N_PT + 1))
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [TERM_AW-1:0]          cfg_addr,
    input  logic [2*(N_IN+N_SEC)-1:0]   cfg_data,
    input  logic [N_IN-1:0]             ded_in,
    input  logic [N_SEC-1:0]            pin_in,
    output logic [N_SEC-1:0]            out_val,
    output logic [N_SEC-1:0]            out_en,
    output logic [N_SEC-1:0]            loop_err
);
    localparam int N_TERM = N_SEC * (N_PT + 1);
    localparam int TW     = 2 * (N_IN + N_SEC);
    // An acyclic chain through N_SEC sections settles within N_SEC+1 passes (R7)
    localparam int N_LVL  = N_SEC + 1;

    logic [N_TERM-1:0][TW-1:0] fuses;

    pal_fuse_store #(
        .N_IN(N_IN), .N_SEC(N_SEC), .N_PT(N_PT), .TERM_AW(TERM_AW)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .fuses    (fuses),
        .loop_err (loop_err)
    );

    // Unrolled settle levels: each level sees the pins the previous one drove (R6, R7)
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        logic [N_SEC-1:0] fb, v, e;
        if (l == 0) begin : g_first
            assign fb = pin_in;
        end else begin : g_next
            assign fb = (g_lvl[l-1].e & g_lvl[l-1].v) | (~g_lvl[l-1].e & pin_in);
        end
        pal_plane #(
            .N_IN(N_IN), .N_SEC(N_SEC), .N_PT(N_PT)
        ) u_plane (
            .fuses  (fuses),
            .ded_in (ded_in),
            .fb     (fb),
            .val    (v),
            .en     (e)
        );
    end

    assign out_val = g_lvl[N_LVL-1].v;
    assign out_en  = g_lvl[N_LVL-1].e;

    // R1: the cycle after a reset edge shows a blank array
    a_r1_blank_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (out_val == '0 && out_en == '0 && loop_err == '0));

endmodule

// File: tb/pal_core_tb_top.sv
`timescale 1ns/1ps
module pal_core_tb_top;
    localparam int NI = 4;
    localparam int NS = 4;
    localparam int NP = 4;
    localparam int NT = NS * (NP + 1);
    localparam int TWB = 2 * (NI + NS);
    localparam int AWB = $clog2(NT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [AWB-1:0] cfg_addr = '0;
    logic [TWB-1:0] cfg_data = '0;
    logic [NI-1:0] ded_in = '0;
    logic [NS-1:0] pin_in = '0;
    logic [NS-1:0] out_val, out_en, loop_err;

    always #2.5 clk = ~clk;

    pal_core #(.N_IN(NI), .N_SEC(NS), .N_PT(NP)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .ded_in(ded_in), .pin_in(pin_in), .out_val(out_val), .out_en(out_en), .loop_err(loop_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [TWB-1:0] mterm [NT];

    localparam logic [1:0] CT = 2'b01, CC = 2'b10;
    localparam logic [TWB-1:0] ANYW = '1, ZEROW = '0;

    // Word with all fields ignored except signal j
    function automatic logic [TWB-1:0] lit(int j, logic [1:0] c);
        logic [TWB-1:0] w = '1;
        w[2*j +: 2] = c;
        return w;
    endfunction

    function automatic int adr(int s, int k);
        return s * (NP + 1) + k;
    endfunction

    // Behavioural reference: iterate the pins until nothing moves
    task automatic model(input logic [NI-1:0] d, input logic [NS-1:0] p,
                         output logic [NS-1:0] v, output logic [NS-1:0] e);
        logic [NS-1:0] fb = p;
        logic [NS-1:0] nfb;
        for (int it = 0; it < 12; it++) begin
            for (int s = 0; s < NS; s++) begin
                v[s] = 1'b0;
                for (int k = 0; k <= NP; k++) begin
                    logic h = 1'b1;
                    for (int j = 0; j < NI + NS; j++) begin
                        logic sg = (j < NI) ? d[j] : fb[j-NI];
                        case (mterm[adr(s, k)][2*j +: 2])
                            2'b00: h = 1'b0;
                            2'b01: h = h & sg;
                            2'b10: h = h & ~sg;
                            default: ;
                        endcase
                    end
                    if (k < NP) v[s] = v[s] | h;
                    else        e[s] = h;
                end
            end
            nfb = (e & v) | (~e & p);
            if (nfb == fb) break;
            fb = nfb;
        end
    endtask

    task automatic chk(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (ded=%b pin=%b)", req, act, exp, ded_in, pin_in);
        end
    endtask

    task automatic wr(int a, logic [TWB-1:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AWB'(a); cfg_data = w;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NT) mterm[a] = w;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int t = 0; t < NT; t++) mterm[t] = '0;
    endtask

    // Apply one vector and compare with the reference
    task automatic vec(string req, logic [NI-1:0] d, logic [NS-1:0] p);
        logic [NS-1:0] ev, ee;
        @(negedge clk);
        ded_in = d; pin_in = p;
        #1;
        model(d, p, ev, ee);
        chk({req, " val"}, out_val, ev);
        chk({req, " en"}, out_en, ee);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) mterm[t] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: blank after reset
        @(negedge clk); ded_in = 4'hF; pin_in = 4'hA; #1;
        chk("R1 val", out_val, '0);
        chk("R1 en", out_en, '0);
        chk("R1 err", loop_err, '0);

        // R8: write takes effect at the edge, not before
        wr(adr(1, NP), ANYW);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AWB'(adr(1, 0)); cfg_data = ANYW;
        #1 chk("R8 before edge", out_val, 4'b0000);
        @(posedge clk); #1;
        cfg_we = 1'b0; mterm[adr(1, 0)] = ANYW;
        chk("R8 after edge", out_val, 4'b0010);

        // Config A: literals, constants, feedback selection
        wr(adr(0, 0), lit(0, CT) & lit(1, CC));
        wr(adr(0, 1), lit(NI + 3, CT));
        wr(adr(0, NP), ANYW);
        wr(adr(2, NP), ANYW);
        wr(adr(3, 0), lit(2, CT));
        wr(adr(3, 1), lit(NI + 1, CC));
        wr(adr(3, NP), lit(3, CT));
        for (int d = 0; d < 16; d++)
            for (int p = 0; p < 16; p++)
                vec("R2 R3 R4 R5 R6", 4'(d), 4'(p));
        // R9: constant one and constant zero sections
        vec("R9", 4'h5, 4'h0);
        chk("R9 const", {out_val[2], out_val[1]}, 2'b01);
        // R6: undriven pin 3 passes pin_in, driven pin 3 passes section 3 value
        vec("R6", 4'b0000, 4'b1000);
        chk("R6 undriven", {3'b000, out_val[0]}, 4'b0001);
        vec("R6", 4'b1000, 4'b1000);
        chk("R6 driven", {3'b000, out_val[0]}, 4'b0000);

        // Config B: six-product function via helper in section 2
        do_reset();
        wr(adr(2, 0), lit(0, CT) & lit(1, CT));
        wr(adr(2, 1), lit(0, CC) & lit(2, CT));
        wr(adr(2, 2), lit(1, CT) & lit(2, CC) & lit(3, CT));
        wr(adr(2, 3), lit(0, CT) & lit(1, CC) & lit(3, CC));
        wr(adr(2, NP), ANYW);
        wr(adr(0, 0), lit(NI + 2, CT));
        wr(adr(0, 1), lit(2, CT) & lit(3, CT));
        wr(adr(0, 2), lit(0, CC) & lit(1, CC) & lit(2, CC) & lit(3, CC));
        wr(adr(0, NP), ANYW);
        wr(adr(1, 0), lit(NI + 3, CT));
        wr(adr(1, NP), ANYW);
        wr(adr(3, 0), lit(1, CT));
        wr(adr(3, NP), lit(0, CT));
        for (int d = 0; d < 16; d++) begin
            for (int p = 0; p < 16; p++) begin
                logic a, b, c, e;
                logic f, mx;
                a = d[0]; b = d[1]; c = d[2]; e = d[3];
                f = (a & b) | (~a & c) | (b & ~c & e) | (a & ~b & ~e) | (c & e) | (~a & ~b & ~c & ~e);
                mx = a ? b : p[3];
                vec("R7 R4", 4'(d), 4'(p));
                chk("R7 six-product", {3'b000, out_val[0]}, {3'b000, f});
                chk("R6 mux", {3'b000, out_val[1]}, {3'b000, mx});
            end
        end

        // R8: out-of-range addresses change nothing
        wr(NT, ANYW);
        wr((1 << AWB) - 1, ANYW);
        for (int d = 0; d < 16; d++) vec("R8 range", 4'(d), 4'h6);

        // R10: hazard flagged one clock late and held
        wr(adr(0, 3), lit(NI + 0, CT));
        #1 chk("R10 not yet", loop_err, 4'b0000);
        @(negedge clk); #1;
        chk("R10 raised", loop_err, 4'b0001);
        wr(adr(0, 3), ZEROW);
        repeat (2) @(negedge clk);
        #1 chk("R10 sticky", loop_err, 4'b0001);
        do_reset();
        #1 chk("R1 err cleared", loop_err, 4'b0000);
        chk("R1 val cleared", out_val, 4'b0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule